// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache with Selectable Allocate and Write Policies

This block is a first-level data cache between a processor load/store port and a word-wide memory bus. It holds four ways of 256 sets, and each set line is eight 32-bit words. The tags are taken from physical addresses. The processor side presents one word read or write at a time through a valid/ready handshake. The cache reports completion with a one-cycle response pulse, and that pulse carries the read data. On a miss the controller may need to write a dirty victim back and then fetch a new line. The memory side carries out this work one word at a time, and each word is acknowledged before the next one starts.

Two static configuration inputs select the policy. The allocate select chooses whether write misses bring the line in (read-write-allocate) or bypass the cache (read-allocate). The write select chooses between write-through and write-back. The configuration is meant to change only while reset is held.

The controller has the states CLEAR, IDLE, LOOKUP, EVICT, FILL, WRMEM and DONE. Reset enters CLEAR, which wipes one set per cycle, and moves to IDLE after the last set. IDLE accepts a request and moves to LOOKUP. LOOKUP has four exits:
- A read hit goes to DONE.
- A write hit goes to DONE in write-back mode, or to WRMEM in write-through mode.
- A miss that allocates goes to EVICT if the victim is dirty, or to FILL otherwise.
- A write miss that does not allocate goes to WRMEM.

EVICT moves to FILL after the eighth word. FILL returns to LOOKUP after the eighth word, and that second lookup then hits. WRMEM moves to DONE on its acknowledge, and DONE returns to IDLE.

Top module: `l1d_cache`

## Requirements
- R1: Addresses split as tag = bits [31:13], set = bits [12:5], word = bits [4:2]; bits [1:0] are ignored. A read always returns the most recent value written to that word, in every policy combination.
- R2: A lookup hits only when a way of the set is valid and its stored tag equals the address tag. A read hit completes with no memory-bus transaction.
- R3: A read miss fetches the whole line as eight read transactions at the line base plus 0, 4, ..., 28 in that order, then returns the requested word.
- R4: With cfg_wr_alloc = 0, a write miss performs exactly one memory write at the request address and leaves the cache unchanged, so a following read of that line misses.
- R5: With cfg_wr_alloc = 1, a write miss first fetches the line (eight reads), then applies the write to the cached line, following the write policy.
- R6: With cfg_write_back = 0, a write hit updates the cached word and performs one memory write at the request address. Lines never become dirty, so no eviction write-back ever occurs.
- R7: With cfg_write_back = 1, a write hit updates only the cached word, with no memory transaction, and marks the line dirty.
- R8: On allocation the lowest-numbered invalid way of the set is used. When all four are valid, a per-set round-robin pointer chooses the victim. The pointer starts at way 0 and advances by one, wrapping after way 3, each time a valid line is replaced.
- R9: A dirty victim is written back before the fill begins. The write-back is eight memory writes at {stored tag, set, word 0..7} in ascending order, carrying the cached data.
- R10: After reset, req_ready stays low for exactly 256 cycles while every line's valid and dirty bits and every pointer are cleared. Afterwards every line misses.
- R11: While mem_req is high and mem_ack has not yet been given, mem_addr, mem_we and (for writes) mem_wdata hold steady.
- R12: Each accepted request produces exactly one rsp_valid pulse of one cycle. req_ready is high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_alloc | input | 1 | 1 = write misses allocate, 0 = only reads allocate |
| cfg_write_back | input | 1 | 1 = write-back, 0 = write-through |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid on reads |
| mem_req | output | 1 | Memory transaction request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge of the current transaction |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The hardest situations to reach from the ports are the ones that need a full set:
- a round-robin replacement after all four ways are valid;
- a dirty victim being written back just ahead of a fill.

The stimulus reaches them by reading four different tags into one set and, for the dirty case, writing one of them under write-back. It then reads further tags into that set. The pattern of memory transactions shows which line was displaced: whether a fill occurs, and whether eight write-backs precede it at the old tag's address. The memory responder varies its acknowledge latency, and each sequence is repeated under all four policy combinations.

// File: rtl/l1d_cache_pkg.sv
package l1d_cache_pkg;
    typedef enum logic [2:0] {
        S_CLEAR,
        S_IDLE,
        S_LOOKUP,
        S_EVICT,
        S_FILL,
        S_WRMEM,
        S_DONE
    } cstate_t;
endpackage

// File: rtl/l1d_tag_store.sv
module l1d_tag_store #(
    parameter int WAYS     = 4,
    parameter int SET_BITS = 8,
    parameter int TAG_W    = 19,
    localparam int SETS    = 1 << SET_BITS,
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                        clk,
    input  logic                        clr,
    input  logic [SET_BITS-1:0]         clr_idx,
    input  logic [SET_BITS-1:0]         idx,
    input  logic                        wr_en,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic                        wr_valid,
    input  logic                        wr_dirty,
    input  logic                        rr_adv,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_dirty,
    output logic [WAY_W-1:0]            rd_rr
);
    logic [WAY_W-1:0] rr_q [SETS];

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [TAG_W-1:0] tag_q   [SETS];
        logic             valid_q [SETS];
        logic             dirty_q [SETS];

        always_ff @(posedge clk) begin
            if (clr) begin
                valid_q[clr_idx] <= 1'b0;
                dirty_q[clr_idx] <= 1'b0;
            end else if (wr_en && wr_way == WAY_W'(g)) begin
                tag_q[idx]   <= wr_tag;
                valid_q[idx] <= wr_valid;
                dirty_q[idx] <= wr_dirty;
            end
        end

        assign rd_tag[g]   = tag_q[idx];
        assign rd_valid[g] = valid_q[idx];
        assign rd_dirty[g] = dirty_q[idx];
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            rr_q[clr_idx] <= '0;
        end else if (rr_adv) begin
            rr_q[idx] <= (rr_q[idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[idx] + 1'b1;
        end
    end

    assign rd_rr = rr_q[idx];
endmodule

// File: rtl/l1d_data_store.sv
module l1d_data_store #(
    parameter int WAYS      = 4,
    parameter int SET_BITS  = 8,
    parameter int WORD_BITS = 3,
    parameter int DATA_W    = 32,
    localparam int DEPTH    = 1 << (SET_BITS + WORD_BITS),
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                         clk,
    input  logic [SET_BITS-1:0]          idx,
    input  logic [WORD_BITS-1:0]         rd_word,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_data,
    input  logic                         wr_en,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [WORD_BITS-1:0]         wr_word,
    input  logic [DATA_W-1:0]            wr_data
);
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [DATA_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_W'(g)) begin
                mem_q[{idx, wr_word}] <= wr_data;
            end
        end

        assign rd_data[g] = mem_q[{idx, rd_word}];
    end
endmodule

// File: rtl/l1d_victim_sel.sv
module l1d_victim_sel #(
    parameter int WAYS   = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAY_W-1:0] rr,
    output logic [WAY_W-1:0] way,
    output logic             was_valid
);
    always_comb begin
        way       = rr;
        was_valid = 1'b1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                way       = WAY_W'(w);
                was_valid = 1'b0;
            end
        end
    end
endmodule

// File: rtl/l1d_cache.sv
module l1d_cache
    import l1d_cache_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int WAYS      = 4,
    parameter int SET_BITS  = 8,
    parameter int WORD_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_alloc,
    input  logic              cfg_write_back,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_BITS = 2;
    localparam int WA_W     = ADDR_W - OFF_BITS;
    localparam int TAG_W    = WA_W - SET_BITS - WORD_BITS;
    localparam int SETS     = 1 << SET_BITS;
    localparam int WORDS    = 1 << WORD_BITS;
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [WORD_BITS-1:0] LAST_WORD = WORD_BITS'(WORDS - 1);
    localparam logic [SET_BITS-1:0]  LAST_SET  = SET_BITS'(SETS - 1);

    cstate_t state, state_nx;

    logic                 cur_we;
    logic [WA_W-1:0]      cur_waddr;
    logic [DATA_W-1:0]    cur_wdata;
    logic [WORD_BITS-1:0] cnt;
    logic [WAY_W-1:0]     vway;
    logic [SET_BITS-1:0]  clr_idx;
    logic [DATA_W-1:0]    rdata_q;

    logic [WORD_BITS-1:0] cur_word;
    logic [SET_BITS-1:0]  cur_idx;
    logic [TAG_W-1:0]     cur_tag;

    assign cur_word = cur_waddr[WORD_BITS-1:0];
    assign cur_idx  = cur_waddr[WORD_BITS +: SET_BITS];
    assign cur_tag  = cur_waddr[WA_W-1 -: TAG_W];

    logic [WAYS-1:0][TAG_W-1:0]  ts_tag;
    logic [WAYS-1:0]             ts_valid;
    logic [WAYS-1:0]             ts_dirty;
    logic [WAY_W-1:0]            ts_rr;
    logic                        ts_clr;
    logic                        ts_wr_en;
    logic [WAY_W-1:0]            ts_wr_way;
    logic [TAG_W-1:0]            ts_wr_tag;
    logic                        ts_wr_valid;
    logic                        ts_wr_dirty;
    logic                        ts_rr_adv;

    logic [WAYS-1:0][DATA_W-1:0] ds_rd_data;
    logic [WORD_BITS-1:0]        ds_rd_word;
    logic                        ds_wr_en;
    logic [WAY_W-1:0]            ds_wr_way;
    logic [WORD_BITS-1:0]        ds_wr_word;
    logic [DATA_W-1:0]           ds_wr_data;

    logic [WAYS-1:0]  hit_vec;
    logic             any_hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] vic_way;
    logic             vic_was_valid;

    l1d_tag_store #(
        .WAYS(WAYS), .SET_BITS(SET_BITS), .TAG_W(TAG_W)
    ) u_tags (
        .clk      (clk),
        .clr      (ts_clr),
        .clr_idx  (clr_idx),
        .idx      (cur_idx),
        .wr_en    (ts_wr_en),
        .wr_way   (ts_wr_way),
        .wr_tag   (ts_wr_tag),
        .wr_valid (ts_wr_valid),
        .wr_dirty (ts_wr_dirty),
        .rr_adv   (ts_rr_adv),
        .rd_tag   (ts_tag),
        .rd_valid (ts_valid),
        .rd_dirty (ts_dirty),
        .rd_rr    (ts_rr)
    );

    l1d_data_store #(
        .WAYS(WAYS), .SET_BITS(SET_BITS), .WORD_BITS(WORD_BITS), .DATA_W(DATA_W)
    ) u_data (
        .clk     (clk),
        .idx     (cur_idx),
        .rd_word (ds_rd_word),
        .rd_data (ds_rd_data),
        .wr_en   (ds_wr_en),
        .wr_way  (ds_wr_way),
        .wr_word (ds_wr_word),
        .wr_data (ds_wr_data)
    );

    l1d_victim_sel #(.WAYS(WAYS)) u_victim (
        .valid     (ts_valid),
        .rr        (ts_rr),
        .way       (vic_way),
        .was_valid (vic_was_valid)
    );

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = ts_valid[w] && (ts_tag[w] == cur_tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        any_hit = |hit_vec;
    end

    assign ds_rd_word = (state == S_EVICT) ? cnt : cur_word;
    assign rsp_rdata  = rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_CLEAR;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_idx   <= '0;
            cnt       <= '0;
            vway      <= '0;
            rdata_q   <= '0;
            cur_we    <= 1'b0;
            cur_waddr <= '0;
            cur_wdata <= '0;
        end else begin
            if (state == S_CLEAR) clr_idx <= clr_idx + 1'b1;
            if (state == S_IDLE && req_valid) begin
                cur_we    <= req_we;
                cur_waddr <= req_addr[ADDR_W-1:OFF_BITS];
                cur_wdata <= req_wdata;
            end
            if (state == S_LOOKUP && !any_hit) begin
                vway <= vic_way;
                cnt  <= '0;
            end
            if (state == S_LOOKUP && any_hit && !cur_we) rdata_q <= ds_rd_data[hit_way];
            if ((state == S_EVICT || state == S_FILL) && mem_ack) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx    = state;
        req_ready   = 1'b0;
        rsp_valid   = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        ts_clr      = 1'b0;
        ts_wr_en    = 1'b0;
        ts_wr_way   = hit_way;
        ts_wr_tag   = cur_tag;
        ts_wr_valid = 1'b1;
        ts_wr_dirty = 1'b0;
        ts_rr_adv   = 1'b0;
        ds_wr_en    = 1'b0;
        ds_wr_way   = hit_way;
        ds_wr_word  = cur_word;
        ds_wr_data  = cur_wdata;
        unique case (state)
            S_CLEAR: begin
                ts_clr = 1'b1;
                if (clr_idx == LAST_SET) state_nx = S_IDLE;
            end
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_nx = S_LOOKUP;
            end
            S_LOOKUP: begin
                if (any_hit) begin
                    if (!cur_we) begin
                        state_nx = S_DONE;
                    end else begin
                        ds_wr_en = 1'b1;
                        if (cfg_write_back) begin
                            ts_wr_en    = 1'b1;
                            ts_wr_dirty = 1'b1;
                            state_nx    = S_DONE;
                        end else begin
                            state_nx = S_WRMEM;
                        end
                    end
                end else if (!cur_we || cfg_wr_alloc) begin
                    ts_rr_adv = vic_was_valid;
                    state_nx  = (vic_was_valid && ts_dirty[vic_way]) ? S_EVICT : S_FILL;
                end else begin
                    state_nx = S_WRMEM;
                end
            end
            S_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {ts_tag[vway], cur_idx, cnt, 2'b00};
                mem_wdata = ds_rd_data[vway];
                if (mem_ack && cnt == LAST_WORD) state_nx = S_FILL;
            end
            S_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {cur_tag, cur_idx, cnt, 2'b00};
                if (mem_ack) begin
                    ds_wr_en   = 1'b1;
                    ds_wr_way  = vway;
                    ds_wr_word = cnt;
                    ds_wr_data = mem_rdata;
                    if (cnt == LAST_WORD) begin
                        ts_wr_en  = 1'b1;
                        ts_wr_way = vway;
                        state_nx  = S_LOOKUP;
                    end
                end
            end
            S_WRMEM: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {cur_waddr, 2'b00};
                mem_wdata = cur_wdata;
                if (mem_ack) state_nx = S_DONE;
            end
            S_DONE: begin
                rsp_valid = 1'b1;
                state_nx  = S_IDLE;
            end
            default: state_nx = S_CLEAR;
        endcase
    end
endmodule

// File: rtl/l1d_cache_chk.sv
module l1d_cache_chk
    import l1d_cache_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int WAYS      = 4,
    parameter int WORD_BITS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_alloc,
    input logic              cfg_write_back,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input cstate_t           state,
    input logic              cur_we,
    input logic [WAYS-1:0]   ts_dirty
);
    localparam logic [WORD_BITS-1:0] LASTW = WORD_BITS'((1 << WORD_BITS) - 1);

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && (!mem_we || $stable(mem_wdata)))); // R11

    AST_BURST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (state == S_FILL || state == S_EVICT)
         && mem_addr[2 +: WORD_BITS] != LASTW)
        |=> (mem_req && mem_addr[2 +: WORD_BITS] == $past(mem_addr[2 +: WORD_BITS]) + 1'b1)); // R3

    AST_NOALLOC_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_alloc && mem_req && !mem_we) |-> !cur_we); // R4

    AST_WT_NEVER_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_write_back && state != S_CLEAR) |-> (ts_dirty == '0)); // R6

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R12
endmodule

bind l1d_cache l1d_cache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .WORD_BITS(WORD_BITS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr_alloc   (cfg_wr_alloc),
    .cfg_write_back (cfg_write_back),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_ack        (mem_ack),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .state          (state),
    .cur_we         (cur_we),
    .ts_dirty       (ts_dirty)
);

// File: tb/l1d_cache_tb.sv
module l1d_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_alloc = 1'b0;
    logic        cfg_write_back = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    always #2.5 clk = ~clk;

    l1d_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_alloc(cfg_wr_alloc), .cfg_write_back(cfg_write_back),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // bench memory covers tags 0..7, sets 0..31
    logic [31:0] bmem [2048];
    logic [31:0] gold [2048];
    logic [31:0] log_addr [1024];
    logic        log_we   [1024];
    logic [31:0] log_data [1024];
    int          n_tr = 0;
    int          lat = 0;
    int          hold_viol = 0;
    logic        pend = 1'b0;
    logic [31:0] p_addr, p_data;
    logic        p_we;
    logic        seeded = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;

    function automatic int midx(input logic [31:0] a);
        return int'({a[15:13], a[9:5], a[4:2]});
    endfunction

    function automatic logic [31:0] initv(input int i);
        return (i * 32'h0100_0193) ^ 32'h3C5A_0000;
    endfunction

    function automatic logic [31:0] line(input int t, input int s);
        return (t << 13) | (s << 5);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat     <= 0;
            pend    <= 1'b0;
            if (!seeded) begin
                for (int i = 0; i < 2048; i++) bmem[i] = initv(i);
                seeded = 1'b1;
            end
        end else begin
            if (pend && (mem_addr != p_addr || mem_we != p_we || (mem_we && mem_wdata != p_data)))
                hold_viol++;
            pend   <= mem_req && !mem_ack;
            p_addr <= mem_addr;
            p_we   <= mem_we;
            p_data <= mem_wdata;
            if (mem_ack) begin
                mem_ack <= 1'b0;
            end else if (mem_req) begin
                if (lat >= (n_tr % 3)) begin
                    mem_ack <= 1'b1;
                    lat     <= 0;
                    log_addr[n_tr & 1023] = mem_addr;
                    log_we[n_tr & 1023]   = mem_we;
                    log_data[n_tr & 1023] = mem_wdata;
                    if (mem_we) bmem[midx(mem_addr)] = mem_wdata;
                    else        mem_rdata <= bmem[midx(mem_addr)];
                    n_tr++;
                end else begin
                    lat <= lat + 1;
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog R12 actual=no completion expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail + 1);
        $finish;
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic chk_burst(input string rq, input int from, input logic we, input logic [31:0] base);
        for (int i = 0; i < 8; i++) begin
            chk(rq, log_addr[(from + i) & 1023], base + 32'(4 * i));
            chk(rq, 32'(log_we[(from + i) & 1023]), 32'(we));
        end
    endtask

    task automatic op(input logic we, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int b, output int n);
        b = n_tr;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        rd = rsp_rdata;
        n  = n_tr - b;
        @(negedge clk);
        chk("R12 pulse", 32'(rsp_valid), 32'd0);
        chk("R12 ready", 32'(req_ready), 32'd1);
    endtask

    task automatic do_reset(input logic wa, input logic wb);
        int lowc;
        rst_n = 1'b0;
        cfg_wr_alloc   = wa;
        cfg_write_back = wb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        lowc = 0;
        while (!req_ready && lowc < 1000) begin
            lowc++;
            @(negedge clk);
        end
        chk("R10 ready-low cycles", 32'(lowc), 32'd256);
        for (int i = 0; i < 2048; i++) gold[i] = bmem[i];
    endtask

    initial begin
        logic [31:0] rd, a, v, old;
        int b, n;
        for (int m = 0; m < 4; m++) begin
            logic wa, wb;
            wa = m[0];
            wb = m[1];
            do_reset(wa, wb);

            // A: read miss fills line, also proves lines invalid after reset
            a = line(1, 3) + 20;
            op(1'b0, a, '0, rd, b, n);
            chk("R10 miss after reset", 32'(n), 32'd8);
            chk_burst("R3 fill order", b, 1'b0, line(1, 3));
            chk("R1 read data", rd, gold[midx(a)]);
            // B: read hit
            op(1'b0, line(1, 3) + 8, '0, rd, b, n);
            chk("R2 hit no traffic", 32'(n), 32'd0);
            chk("R2 hit data", rd, gold[midx(line(1, 3) + 8)]);
            // C: write hit
            old = gold[midx(a)];
            v = 32'hA000_0000 | 32'(m);
            op(1'b1, a, v, rd, b, n);
            gold[midx(a)] = v;
            if (!wb) begin
                chk("R6 wt one write", 32'(n), 32'd1);
                chk("R6 wt addr", log_addr[b & 1023], a);
                chk("R6 wt memory", bmem[midx(a)], v);
            end else begin
                chk("R7 wb no traffic", 32'(n), 32'd0);
                chk("R7 wb memory untouched", bmem[midx(a)], old);
            end
            op(1'b0, a, '0, rd, b, n);
            chk("R1 read after write", rd, v);
            chk("R2 hit after write", 32'(n), 32'd0);

            // E: write miss
            a = line(2, 3) + 4;
            v = 32'hB000_0000 | 32'(m);
            op(1'b1, a, v, rd, b, n);
            gold[midx(a)] = v;
            if (!wa) begin
                chk("R4 no-alloc single write", 32'(n), 32'd1);
                chk("R4 write addr", log_addr[b & 1023], a);
                chk("R4 write is write", 32'(log_we[b & 1023]), 32'd1);
                chk("R4 memory", bmem[midx(a)], v);
            end else begin
                chk("R5 alloc traffic", 32'(n), wb ? 32'd8 : 32'd9);
                chk_burst("R5 alloc fill", b, 1'b0, line(2, 3));
                if (!wb) chk("R5 wt after fill", log_addr[(b + 8) & 1023], a);
            end
            op(1'b0, a, '0, rd, b, n);
            chk("R1 read write-miss data", rd, v);
            if (!wa) chk("R4 cache unchanged", 32'(n), 32'd8);
            else     chk("R5 line present", 32'(n), 32'd0);

            // G: victim choice in set 7
            for (int t = 1; t <= 4; t++) begin
                op(1'b0, line(t, 7), '0, rd, b, n);
                chk("R8 fill invalid way", 32'(n), 32'd8);
            end
            for (int t = 1; t <= 4; t++) begin
                op(1'b0, line(t, 7), '0, rd, b, n);
                chk("R8 all four kept", 32'(n), 32'd0);
                chk("R1 set7 data", rd, gold[midx(line(t, 7))]);
            end
            op(1'b0, line(5, 7), '0, rd, b, n);
            chk("R8 tag5 miss", 32'(n), 32'd8);
            chk_burst("R8 tag5 fill", b, 1'b0, line(5, 7));
            op(1'b0, line(2, 7), '0, rd, b, n);
            chk("R8 way1 survived", 32'(n), 32'd0);
            op(1'b0, line(1, 7), '0, rd, b, n);
            chk("R8 way0 replaced", 32'(n), 32'd8);
            op(1'b0, line(2, 7), '0, rd, b, n);
            chk("R8 rr moved to way1", 32'(n), 32'd8);
            op(1'b0, line(4, 7), '0, rd, b, n);
            chk("R8 way3 survived", 32'(n), 32'd0);
            op(1'b0, line(3, 7), '0, rd, b, n);
            chk("R8 way2 replaced", 32'(n), 32'd8);

            // H: dirty eviction in set 9
            for (int t = 1; t <= 4; t++) op(1'b0, line(t, 9), '0, rd, b, n);
            a = line(1, 9) + 12;
            v = 32'hC000_0000 | 32'(m);
            op(1'b1, a, v, rd, b, n);
            gold[midx(a)] = v;
            op(1'b0, line(5, 9), '0, rd, b, n);
            if (wb) begin
                chk("R9 evict plus fill", 32'(n), 32'd16);
                chk_burst("R9 writeback order", b, 1'b1, line(1, 9));
                for (int i = 0; i < 8; i++)
                    chk("R9 writeback data", log_data[(b + i) & 1023], gold[midx(line(1, 9) + 32'(4 * i))]);
                chk_burst("R9 fill after writeback", b + 8, 1'b0, line(5, 9));
                chk("R9 memory holds dirty word", bmem[midx(a)], v);
            end else begin
                chk("R6 clean victim no writeback", 32'(n), 32'd8);
                chk_burst("R6 fill only", b, 1'b0, line(5, 9));
            end
            op(1'b0, a, '0, rd, b, n);
            chk("R1 data after eviction", rd, v);

            // I: word sweep in set 20
            for (int w = 0; w < 8; w++) begin
                v = 32'h5A00_0000 | 32'(m << 8) | 32'(w);
                op(1'b1, line(3, 20) + 32'(4 * w), v, rd, b, n);
                gold[midx(line(3, 20) + 32'(4 * w))] = v;
            end
            for (int w = 0; w < 8; w++) begin
                op(1'b0, line(3, 20) + 32'(4 * w) + 32'(w & 3), '0, rd, b, n);
                chk("R1 word sweep", rd, 32'h5A00_0000 | 32'(m << 8) | 32'(w));
            end

            // J: set sweep, tag 6 never used before
            for (int s = 0; s < 32; s++) begin
                a = line(6, s) + 32'(4 * (s % 8));
                op(1'b0, a, '0, rd, b, n);
                chk("R3 sweep miss", 32'(n), 32'd8);
                chk("R1 sweep data", rd, gold[midx(a)]);
            end
        end
        chk("R11 request hold", 32'(hold_viol), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule